// File: doc/BRIEF.md
# Selectable-Mode Binary Rounding Unit

This unit takes an unsigned significand that carries a few extra low-order guard bits, together with the sign of the value it belongs to and a two-bit mode select. It returns the significand cut back to its kept width. The guard bits decide whether the kept part is raised by one unit in the last place. When that raise overflows the kept width, a carry-out flag is set, so a later normalization stage can shift and adjust the exponent.

The significand input is laid out with the kept part in the upper bits `sig_i[KEEP_W+GUARD_W-1:GUARD_W]` and the guard bits in the lower bits `sig_i[GUARD_W-1:0]`. The defaults are 24 kept bits and 3 guard bits. The result is registered, so it appears one clock after its inputs.

The mode codes are:
- 0: nearest, ties to even.
- 1: toward zero.
- 2: toward positive infinity.
- 3: toward negative infinity.

The sign matters only in the two directed modes. It decides whether raising the magnitude moves the value up or down.

Top module: `round_unit`

## Requirements
- R1: While `rst_ni` is low, `rounded_o` and `carry_o` are zero.
- R2: The outputs present the rounding of the inputs sampled at the previous rising clock edge, and hold between edges.
- R3: In mode 1 (toward zero), `rounded_o` equals the kept bits and `carry_o` is 0, for every guard pattern and either sign.
- R4: In mode 2 (toward positive infinity), a positive input (`sign_i`=0) with any nonzero guard bit is incremented. A negative input (`sign_i`=1) is never incremented.
- R5: In mode 3 (toward negative infinity), a negative input with any nonzero guard bit is incremented. A positive input is never incremented.
- R6: In mode 0 (nearest even), the kept bits are incremented when the guard value exceeds half (guard MSB set with any lower guard bit set). They are left unchanged when the guard value is below half.
- R7: In mode 0, an exact halfway guard pattern (MSB 1, rest 0) increments only when the kept LSB `sig_i[GUARD_W]` is 1, so the result always has LSB 0.
- R8: An all-zero guard field leaves the kept bits unchanged and `carry_o` at 0 in every mode.
- R9: When an increment overflows the kept width (kept bits all ones), `rounded_o` is zero and `carry_o` is 1. `carry_o` is never 1 otherwise.
- R10: In modes 0 and 1, the result does not depend on `sign_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sig_i | input | KEEP_W+GUARD_W | Significand: kept bits on top, guard bits below |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mode_i | input | 2 | Rounding mode: 0 nearest even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| rounded_o | output | KEEP_W | Rounded kept significand |
| carry_o | output | 1 | Set when rounding overflows the kept width |

## Verification
Every guard pattern is swept against both signs and all four modes. The sweep is repeated over a set of kept values:
- zero, one and two, whose LSB parity separates ties that go up from ties that stay;
- a mixed-bit value;
- a value one below all ones;
- all ones, which alone can produce the carry.

Pairing each sign with each directed mode shows whether the sign steers the increment the right way. Comparing nearest-even results across signs shows that the sign is ignored there. A separate sequence holds new inputs before a clock edge to confirm the one-cycle latency.

// File: rtl/round_pkg.sv
package round_pkg;
  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_TO_ZERO   = 2'd1,
    RND_UP        = 2'd2,
    RND_DOWN      = 2'd3
  } rnd_mode_e;
endpackage

// File: rtl/round_decide.sv
module round_decide
  import round_pkg::*;
#(
  parameter int GUARD_W = 3
) (
  input  logic [GUARD_W-1:0] guard_i,
  input  logic               lsb_i,
  input  logic               sign_i,
  input  rnd_mode_e          mode_i,
  output logic               inc_o
);
  localparam logic [GUARD_W-1:0] HALF = GUARD_W'(1) << (GUARD_W - 1);

  logic above, tie, sticky;
  assign above  = guard_i > HALF;
  assign tie    = guard_i == HALF;
  assign sticky = |guard_i;

  always_comb begin
    unique case (mode_i)
      RND_NEAR_EVEN: inc_o = above | (tie & lsb_i);
      RND_TO_ZERO:   inc_o = 1'b0;
      RND_UP:        inc_o = sticky & ~sign_i;
      RND_DOWN:      inc_o = sticky & sign_i;
      default:       inc_o = 1'b0;
    endcase
  end

  always_comb begin
    assert_no_inc_exact_R8: assert (sticky || !inc_o);
  end
endmodule

// File: rtl/round_incr.sv
module round_incr #(
  parameter int KEEP_W = 24
) (
  input  logic [KEEP_W-1:0] kept_i,
  input  logic              inc_i,
  output logic [KEEP_W-1:0] sum_o,
  output logic              carry_o
);
  assign {carry_o, sum_o} = {1'b0, kept_i} + {{KEEP_W{1'b0}}, inc_i};
endmodule

// File: rtl/round_unit.sv
module round_unit
  import round_pkg::*;
#(
  parameter int KEEP_W  = 24,
  parameter int GUARD_W = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [KEEP_W+GUARD_W-1:0] sig_i,
  input  logic                      sign_i,
  input  logic [1:0]                mode_i,
  output logic [KEEP_W-1:0]         rounded_o,
  output logic                      carry_o
);
  localparam int TOTAL_W = KEEP_W + GUARD_W;
  localparam logic [GUARD_W-1:0] HALF = GUARD_W'(1) << (GUARD_W - 1);

  logic [KEEP_W-1:0]  kept;
  logic [GUARD_W-1:0] guard;
  logic               inc;
  logic [KEEP_W-1:0]  sum;
  logic               cout;
  rnd_mode_e          mode;

  assign kept  = sig_i[TOTAL_W-1:GUARD_W];
  assign guard = sig_i[GUARD_W-1:0];
  assign mode  = rnd_mode_e'(mode_i);

  round_decide #(.GUARD_W(GUARD_W)) u_decide (
    .guard_i (guard),
    .lsb_i   (kept[0]),
    .sign_i  (sign_i),
    .mode_i  (mode),
    .inc_o   (inc)
  );

  round_incr #(.KEEP_W(KEEP_W)) u_incr (
    .kept_i  (kept),
    .inc_i   (inc),
    .sum_o   (sum),
    .carry_o (cout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rounded_o <= '0;
      carry_o   <= 1'b0;
    end else begin
      rounded_o <= sum;
      carry_o   <= cout;
    end
  end

  assert_carry_wraps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (rounded_o == '0));

  assert_carry_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&kept) |=> !carry_o);

  assert_trunc_keeps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1) |=> (rounded_o == $past(kept)) && !carry_o);

  assert_up_neg_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && sign_i) |=> (rounded_o == $past(kept)) && !carry_o);

  assert_down_pos_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && !sign_i) |=> (rounded_o == $past(kept)) && !carry_o);

  assert_tie_even_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && guard == HALF) |=> !rounded_o[0]);
endmodule

// File: tb/round_unit_tb.sv
`timescale 1ns/1ps
module round_unit_tb;
  localparam int KEEP_W  = 24;
  localparam int GUARD_W = 3;

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic [KEEP_W+GUARD_W-1:0] sig = '0;
  logic                      sign = 1'b0;
  logic [1:0]                mode = 2'd0;
  logic [KEEP_W-1:0]         rounded;
  logic                      carry;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  round_unit #(.KEEP_W(KEEP_W), .GUARD_W(GUARD_W)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sig_i     (sig),
    .sign_i    (sign),
    .mode_i    (mode),
    .rounded_o (rounded),
    .carry_o   (carry)
  );

  task automatic check(string req, logic [KEEP_W:0] act, logic [KEEP_W:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got carry/value %h, expected %h", req, act, exp);
    end
  endtask

  function automatic logic [KEEP_W:0] model(logic [KEEP_W-1:0] k, int g, logic s, int m);
    int half = 1 << (GUARD_W - 1);
    bit up;
    case (m)
      0: up = (g > half) || (g == half && k[0]);
      1: up = 1'b0;
      2: up = (g != 0) && !s;
      default: up = (g != 0) && s;
    endcase
    return {1'b0, k} + (up ? 1 : 0);
  endfunction

  function automatic string tag(logic [KEEP_W-1:0] k, int g, int m, logic [KEEP_W:0] e);
    if (e[KEEP_W]) return "R9";
    if (g == 0) return "R8";
    case (m)
      0: return (g == (1 << (GUARD_W - 1))) ? "R7" : "R6";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic apply(logic [KEEP_W-1:0] k, int g, logic s, int m);
    @(negedge clk);
    sig  = {k, GUARD_W'(g)};
    sign = s;
    mode = 2'(m);
    @(posedge clk);
    #1;
  endtask

  logic [KEEP_W-1:0] kepts [7] = '{24'h000000, 24'h000001, 24'h000002, 24'h123456,
                                   24'hABCDEF, 24'hFFFFFE, 24'hFFFFFF};

  initial begin
    sig  = {24'hFFFFFF, 3'b111};
    mode = 2'd2;
    #9;
    check("R1", {carry, rounded}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int ki = 0; ki < 7; ki++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 2; s++)
          for (int g = 0; g < (1 << GUARD_W); g++) begin
            logic [KEEP_W:0] e;
            e = model(kepts[ki], g, 1'(s), m);
            apply(kepts[ki], g, 1'(s), m);
            check(tag(kepts[ki], g, m, e), {carry, rounded}, e);
          end

    // R10: sign ignored in nearest and toward-zero modes
    for (int m = 0; m < 2; m++)
      for (int g = 0; g < (1 << GUARD_W); g++) begin
        logic [KEEP_W:0] e;
        e = model(24'h00F00D, g, 1'b0, m);
        apply(24'h00F00D, g, 1'b1, m);
        check("R10", {carry, rounded}, e);
      end

    // R2: one-cycle latency, output holds until the next edge
    apply(24'h000010, 7, 1'b0, 2);
    @(negedge clk);
    sig  = {24'h000020, 3'b000};
    mode = 2'd1;
    #1;
    check("R2", {carry, rounded}, 25'h000011);
    @(posedge clk);
    #1;
    check("R2", {carry, rounded}, 25'h000020);

    // R1: asynchronous reset clears outputs mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", {carry, rounded}, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule